// File: doc/BRIEF.md
# Latching Maskable Interrupt Controller

This block gathers a parameterised set of interrupt lines next to a processor core and folds them into one interrupt request. Software reaches it through a small synchronous register port that exposes two words: an enable word with one bit per line, and a pending word with one bit per line. The request to the core is high while any pending bit is also enabled. Software finds the line to service by scanning the pending word from bit 0 upward, so the lowest-numbered line goes first.

Every input first passes through a two-flop synchroniser. A build-time parameter then picks how pending bits behave. In follow mode they mirror the synchronised inputs and need no acknowledge. In edge mode a rising edge sets a sticky bit that software clears by writing 1. In latch-all mode any high input, level or pulse, is captured, and software clears a bit by writing 0 to it.

Top module: `intc_latch`

## Requirements
- R1: While reset is asserted and right after it, the enable word and the pending word read as all zeros and `cpu_irq` is low, whatever the input lines do.
- R2: Writing with `reg_sel`=0 loads the enable word from `reg_wdata` at the clock edge. A 1 in bit n enables line n. `reg_rdata` returns the word that `reg_sel` selects (0 enable, 1 pending) in the same cycle, with no register in between.
- R3: `cpu_irq` is a register that holds the OR over all lines of (pending AND enable) as sampled at the previous clock edge.
- R4: A change on an input line is visible in the pending word three clock edges after it is applied: two synchroniser edges, then the pending register.
- R5: With MODE=0 (follow), the pending word equals the synchronised input levels, and writes with `reg_sel`=1 have no effect on it.
- R6: With MODE=1 (edge), a rising edge on a synchronised line sets its pending bit, and the bit stays set after the line falls.
- R7: With MODE=1, a write with `reg_sel`=1 clears each pending bit whose data bit is 1 and leaves the bits written with 0 unchanged.
- R8: With MODE=2 (latch-all), a line that is high sets its pending bit on every edge, so the bit stays set after the line falls and cannot be cleared while the line is high.
- R9: With MODE=2, a write with `reg_sel`=1 clears each pending bit whose data bit is 0 and keeps the bits written with 1.
- R10: In MODE=1 and MODE=2, when a set and a clear hit the same bit at the same edge, the set wins and the bit ends up 1.
- R11: A pending line whose enable bit is 0 shows in the pending word but does not raise `cpu_irq`. Enabling it raises `cpu_irq` one edge after the enable word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | N | Interrupt lines, asynchronous to clk |
| reg_sel | input | 1 | Word select: 0 enable, 1 pending |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Read data of the selected word, combinational |
| cpu_irq | output | 1 | Registered interrupt request to the core |

## Verification
The bench builds three copies with N=8, one for each MODE value, and drives them from the same input lines, so each stimulus shows how the three clearing rules differ. With eight lines it can sweep every line one at a time and check the exact cycle in which the pending bit and the request change. A clear is also timed to land on the same edge as a new rising edge, to show that the set wins.

// File: rtl/intc_latch.sv
module intc_latch #(
  parameter int N    = 32,
  parameter int MODE = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         reg_sel,
  input  logic         reg_we,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  output logic         cpu_irq
);
  localparam logic [N-1:0] ALL1 = '1;

  logic [N-1:0] s1, s2, status_q, status_d, mask_q;
  logic         irq_q;
  logic         stat_wr;

  assign stat_wr = reg_we && reg_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= irq_in;
      s2 <= s1;
    end

  generate
    if (MODE == 0) begin : g_follow
      assign status_d = s2;
    end else if (MODE == 1) begin : g_edge
      logic [N-1:0] s3, clr;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s3 <= '0;
        else        s3 <= s2;
      assign clr      = stat_wr ? reg_wdata : '0;
      assign status_d = (status_q & ~clr) | (s2 & ~s3);
    end else begin : g_latch
      logic [N-1:0] keep;
      assign keep     = stat_wr ? reg_wdata : ALL1;
      assign status_d = (status_q & keep) | s2;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      if (reg_we && !reg_sel) mask_q <= reg_wdata;
      irq_q    <= |(status_q & mask_q);
    end

  assign reg_rdata = reg_sel ? status_q : mask_q;
  assign cpu_irq   = irq_q;
endmodule

// File: rtl/intc_latch_chk.sv
module intc_latch_chk #(
  parameter int N    = 32,
  parameter int MODE = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_in,
  input logic         reg_sel,
  input logic         reg_we,
  input logic [N-1:0] reg_wdata,
  input logic [N-1:0] status_q,
  input logic [N-1:0] mask_q,
  input logic         cpu_irq
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  // R3
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == $past(|(status_q & mask_q)));

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_sel) |=> mask_q == $past(reg_wdata));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE != 0 && !(reg_we && reg_sel)) |=> (($past(status_q) & ~status_q) == '0));

  // R4
  level_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE == 0 && age == 2'd3) |-> status_q == $past(irq_in, 3));
endmodule

bind intc_latch intc_latch_chk #(.N(N), .MODE(MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_sel(reg_sel),
  .reg_we(reg_we), .reg_wdata(reg_wdata), .status_q(status_q),
  .mask_q(mask_q), .cpu_irq(cpu_irq)
);

// File: tb/intc_latch_test.sv
module intc_latch_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] lines = '0;
  logic         sel [3];
  logic         we  [3];
  logic [W-1:0] wd  [3];
  logic [W-1:0] rd  [3];
  logic         irq [3];
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  for (genvar k = 0; k < 3; k++) begin : g_m
    intc_latch #(.N(W), .MODE(k)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(lines), .reg_sel(sel[k]),
      .reg_we(we[k]), .reg_wdata(wd[k]), .reg_rdata(rd[k]), .cpu_irq(irq[k])
    );
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic nwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr3(input logic s, input logic [W-1:0] d0, input logic [W-1:0] d1,
                     input logic [W-1:0] d2);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin sel[k] = s; we[k] = 1'b1; end
    wd[0] = d0; wd[1] = d1; wd[2] = d2;
    @(negedge clk);
    for (int k = 0; k < 3; k++) we[k] = 1'b0;
  endtask

  task automatic rdc(input int k, input logic s, input logic [W-1:0] exp, input string tag);
    sel[k] = s;
    #1;
    chk($sformatf("%s mode%0d sel%0d", tag, k, s), rd[k], exp);
  endtask

  task automatic irqc(input logic [2:0] exp, input string tag);
    for (int k = 0; k < 3; k++)
      chk($sformatf("%s irq mode%0d", tag, k), {7'd0, irq[k]}, {7'd0, exp[k]});
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int k = 0; k < 3; k++) begin sel[k] = 1'b0; we[k] = 1'b0; wd[k] = '0; end
    lines = 8'hFF;
    nwait(3);
    for (int k = 0; k < 3; k++) begin
      rdc(k, 1'b0, 8'h00, "R1");
      rdc(k, 1'b1, 8'h00, "R1");
    end
    irqc(3'b000, "R1");
    lines = 8'h00;
    rst_n = 1'b1;
    nwait(4);
    for (int k = 0; k < 3; k++) rdc(k, 1'b1, 8'h00, "R1");

    wr3(1'b0, 8'hA5, 8'h5A, 8'hC3);
    rdc(0, 1'b0, 8'hA5, "R2");
    rdc(1, 1'b0, 8'h5A, "R2");
    rdc(2, 1'b0, 8'hC3, "R2");
    wr3(1'b0, 8'hFF, 8'hFF, 8'hFF);
    for (int k = 0; k < 3; k++) rdc(k, 1'b0, 8'hFF, "R2");

    for (int i = 0; i < W; i++) begin
      logic [W-1:0] b;
      b = W'(1) << i;
      @(negedge clk); lines = b;
      nwait(2);
      for (int k = 0; k < 3; k++) rdc(k, 1'b1, 8'h00, "R4 early");
      nwait(1);
      rdc(0, 1'b1, b, "R5");
      rdc(1, 1'b1, b, "R6");
      rdc(2, 1'b1, b, "R8");
      irqc(3'b000, "R3 before");
      nwait(1);
      irqc(3'b111, "R3 raise");
      lines = 8'h00;
      nwait(3);
      rdc(0, 1'b1, 8'h00, "R5 drop");
      rdc(1, 1'b1, b, "R6 hold");
      rdc(2, 1'b1, b, "R8 hold");
      wr3(1'b1, 8'h00, 8'h00, 8'hFF);
      rdc(0, 1'b1, 8'h00, "R5 write");
      rdc(1, 1'b1, b, "R7 zero");
      rdc(2, 1'b1, b, "R9 ones");
      wr3(1'b1, 8'hFF, b, ~b);
      rdc(0, 1'b1, 8'h00, "R5 write");
      rdc(1, 1'b1, 8'h00, "R7 clear");
      rdc(2, 1'b1, 8'h00, "R9 clear");
      nwait(1);
      irqc(3'b000, "R3 drop");
    end

    wr3(1'b0, 8'h00, 8'h00, 8'h00);
    lines = 8'h08;
    nwait(5);
    for (int k = 0; k < 3; k++) rdc(k, 1'b1, 8'h08, "R11 pending");
    irqc(3'b000, "R11 masked");
    wr3(1'b0, 8'h08, 8'h08, 8'h08);
    irqc(3'b000, "R11 lag");
    nwait(1);
    irqc(3'b111, "R11 enable");
    lines = 8'h00;
    nwait(3);
    wr3(1'b1, 8'h00, 8'h08, 8'hF7);
    for (int k = 0; k < 3; k++) rdc(k, 1'b1, 8'h00, "R11 cleared");
    wr3(1'b0, 8'hFF, 8'hFF, 8'hFF);

    lines = 8'h20;
    nwait(4);
    lines = 8'h00;
    nwait(4);
    rdc(1, 1'b1, 8'h20, "R10 setup");
    rdc(2, 1'b1, 8'h20, "R10 setup");
    lines = 8'h20;
    nwait(2);
    sel[1] = 1'b1; sel[2] = 1'b1;
    wd[1] = 8'h20; wd[2] = 8'hDF;
    we[1] = 1'b1;  we[2] = 1'b1;
    @(negedge clk);
    we[1] = 1'b0;  we[2] = 1'b0;
    rdc(1, 1'b1, 8'h20, "R10 edge");
    rdc(2, 1'b1, 8'h20, "R10 latch");
    wr3(1'b1, 8'h00, 8'h00, 8'hDF);
    rdc(2, 1'b1, 8'h20, "R8 high");
    wr3(1'b1, 8'h00, 8'h20, 8'hFF);
    rdc(1, 1'b1, 8'h00, "R7 high");
    lines = 8'h00;
    nwait(3);
    wr3(1'b1, 8'h00, 8'h00, 8'hDF);
    rdc(2, 1'b1, 8'h00, "R9 low");
    nwait(2);
    irqc(3'b000, "R3 idle");

    summary();
  end
endmodule